// File: doc/BRIEF.md
# LCD Video Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe and the column and row of the pixel being shown. Software programs sync widths, porches and the visible size through a simple register write port. The pixel rate is derived from the source clock by a programmable integer divider. A frame interrupt is raised at the start of every vertical sync and held until software clears it.

Each line and each frame is a sequence of four phases: sync, back porch, active, front porch. The divider and the two output-enable bits are held in a pending copy. While the raster runs, that copy moves into the working copy only at the frame boundary, so a reprogrammed divider or a stop request never cuts a frame short. While the raster is stopped, the pending copy is applied at once.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, hsync_o, vsync_o and de_o are 0, x_o and y_o are 0, irq_o is 0 and no raster runs.
- R2: Register map at wr_addr: 0 = horizontal timing (sync width-1 in [7:0], back porch-1 in [15:8], front porch-1 in [23:16], in pixels); 1 = vertical timing (same fields, in lines); 2 = visible size (width-1 in [10:0], height-1 in [26:16]); 3 = control (bit 0 output enable, bit 1 frame output enable, bit 2 divide select, [15:8] divider-1); 4 = polarity (bit 0 hsync, bit 1 vsync, bit 2 data enable; 1 means active low); 5 = interrupt (bit 0 enable, bit 1 write-1-to-clear pending). All registers reset to 0.
- R3: Each line is hsync for the sync width, then the back porch, then the visible width, then the front porch, so a line lasts (sync+back+width+front) pixel periods and data enable first rises sync+back pixel periods after the line starts.
- R4: Each frame is vsync for the vertical sync width in lines, then the vertical back porch, then the visible height, then the vertical front porch, and the next frame follows without a gap.
- R5: de_o is active only in visible columns of visible lines; there x_o runs 0 to width-1 and y_o 0 to height-1, and both are 0 elsewhere.
- R6: The raster advances one pixel every N source-clock cycles, N = divider+1 when divide select is 1 and N = 1 when it is 0 (the divider field is then ignored); N ranges 1 to 256.
- R7: The raster runs only when both enable bits of the control register are 1; with only one of them set, no sync or data-enable pulse appears.
- R8: While the raster runs, a control write changes neither the divider nor the enables until the current frame ends; the new values take effect from the next frame's first pixel. While stopped, a control write takes effect within two cycles.
- R9: A polarity bit of 1 inverts its output, including its idle level while stopped.
- R10: With the interrupt enable set, a pending flag is set on the first pixel of every vsync and drives irq_o; writing 1 to the clear bit drops irq_o on the next cycle; with the enable clear, irq_o stays 0.
- R11: Clearing the enables while the raster runs lets the current frame finish; afterwards all outputs stay at their inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per register 4 |
| vsync_o | output | 1 | Vertical sync, polarity per register 4 |
| de_o | output | 1 | Data enable, polarity per register 4 |
| x_o | output | 11 | Visible column, 0 outside the visible area |
| y_o | output | 11 | Visible row, 0 outside the visible area |
| irq_o | output | 1 | Frame interrupt, level |

## Verification
On every cycle, the assertions check that the working divider and enables change only at a frame boundary while running, and that the divider count stays within its programmed range. They also check that the raster returns to its origin after every frame end, that data enable never shows a column or row beyond the visible size, and that the interrupt pending flag follows its set and clear events. The phase lengths, the frame period in source cycles, the offset of the first visible pixel, and the deferral of a divider change or stop request to the frame end can only be shown by the bench. It measures those at the pins over whole frames, for directed minimum and maximum settings and for random ones.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    localparam int unsigned REG_HTIM = 0;
    localparam int unsigned REG_VTIM = 1;
    localparam int unsigned REG_SIZE = 2;
    localparam int unsigned REG_CTRL = 3;
    localparam int unsigned REG_POL  = 4;
    localparam int unsigned REG_IRQ  = 5;

    // Phase order within a line and within a frame
    function automatic phase_e next_phase(phase_e ph);
        case (ph)
            PH_SYNC:  return PH_BACK;
            PH_BACK:  return PH_ACT;
            PH_ACT:   return PH_FRONT;
            default:  return PH_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3,
    parameter int CNT_W   = 11,
    parameter int PORCH_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               frame_wrap,
    output logic [PORCH_W-1:0] hsw_m1,
    output logic [PORCH_W-1:0] hbp_m1,
    output logic [PORCH_W-1:0] hfp_m1,
    output logic [PORCH_W-1:0] vsw_m1,
    output logic [PORCH_W-1:0] vbp_m1,
    output logic [PORCH_W-1:0] vfp_m1,
    output logic [CNT_W-1:0]   width_m1,
    output logic [CNT_W-1:0]   height_m1,
    output logic [2:0]         pol,
    output logic               irq_en,
    output logic               irq_clr,
    output logic               run,
    output logic               div_sel,
    output logic [DIV_W-1:0]   div_m1
);
    import lcdt_pkg::*;

    localparam int HBP_LSB = 8;
    localparam int HFP_LSB = 16;
    localparam int HGT_LSB = 16;
    localparam int DIV_LSB = 8;

    typedef struct packed {
        logic [PORCH_W-1:0] hsw, hbp, hfp, vsw, vbp, vfp;
        logic [CNT_W-1:0]   wid, hgt;
        logic [2:0]         pol;
        logic               irq_en;
        logic [DIV_W-1:0]   p_div;
        logic               p_sel, p_en, p_en_f;
        logic [DIV_W-1:0]   a_div;
        logic               a_sel, a_en, a_en_f;
    } regs_t;

    regs_t q, d;
    logic  run_q;

    assign run_q = q.a_en & q.a_en_f;

    always_comb begin
        d       = q;
        irq_clr = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(REG_HTIM): begin
                    d.hsw = wr_data[0 +: PORCH_W];
                    d.hbp = wr_data[HBP_LSB +: PORCH_W];
                    d.hfp = wr_data[HFP_LSB +: PORCH_W];
                end
                ADDR_W'(REG_VTIM): begin
                    d.vsw = wr_data[0 +: PORCH_W];
                    d.vbp = wr_data[HBP_LSB +: PORCH_W];
                    d.vfp = wr_data[HFP_LSB +: PORCH_W];
                end
                ADDR_W'(REG_SIZE): begin
                    d.wid = wr_data[0 +: CNT_W];
                    d.hgt = wr_data[HGT_LSB +: CNT_W];
                end
                ADDR_W'(REG_CTRL): begin
                    d.p_en   = wr_data[0];
                    d.p_en_f = wr_data[1];
                    d.p_sel  = wr_data[2];
                    d.p_div  = wr_data[DIV_LSB +: DIV_W];
                end
                ADDR_W'(REG_POL): begin
                    d.pol = wr_data[2:0];
                end
                ADDR_W'(REG_IRQ): begin
                    d.irq_en = wr_data[0];
                    irq_clr  = wr_data[1];
                end
                default: ;
            endcase
        end
        // Working copy follows the pending copy when stopped or at frame end
        if (!run_q || frame_wrap) begin
            d.a_div  = q.p_div;
            d.a_sel  = q.p_sel;
            d.a_en   = q.p_en;
            d.a_en_f = q.p_en_f;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hsw_m1    = q.hsw;
    assign hbp_m1    = q.hbp;
    assign hfp_m1    = q.hfp;
    assign vsw_m1    = q.vsw;
    assign vbp_m1    = q.vbp;
    assign vfp_m1    = q.vfp;
    assign width_m1  = q.wid;
    assign height_m1 = q.hgt;
    assign pol       = q.pol;
    assign irq_en    = q.irq_en;
    assign run       = run_q;
    assign div_sel   = q.a_sel;
    assign div_m1    = q.a_div;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    // R8: while running, the working control copy only moves at a frame end
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !frame_wrap) |=> ($stable(q.a_div) && $stable(q.a_sel) &&
                                    $stable(q.a_en) && $stable(q.a_en_f)));

endmodule

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div_sel,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (!div_sel) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else if (cnt_q >= div_m1) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: the divide counter never exceeds the programmed divider
    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div_sel) |-> (cnt_q <= div_m1));

endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan #(
    parameter int CNT_W   = 11,
    parameter int PORCH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic [PORCH_W-1:0] hsw_m1,
    input  logic [PORCH_W-1:0] hbp_m1,
    input  logic [PORCH_W-1:0] hfp_m1,
    input  logic [PORCH_W-1:0] vsw_m1,
    input  logic [PORCH_W-1:0] vbp_m1,
    input  logic [PORCH_W-1:0] vfp_m1,
    input  logic [CNT_W-1:0]   width_m1,
    input  logic [CNT_W-1:0]   height_m1,
    input  logic [2:0]         pol,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [CNT_W-1:0]   x_o,
    output logic [CNT_W-1:0]   y_o,
    output logic               frame_wrap,
    output logic               frame_start
);
    import lcdt_pkg::*;

    typedef struct packed {
        phase_e           hph;
        logic [CNT_W-1:0] hcnt;
        phase_e           vph;
        logic [CNT_W-1:0] vcnt;
    } scan_t;

    scan_t q, d;
    logic [CNT_W-1:0] hlen, vlen;
    logic h_last, v_last, line_end, frame_end;
    logic hs_act, vs_act, de_act;

    function automatic logic [CNT_W-1:0] seg_len(phase_e ph,
            logic [PORCH_W-1:0] sw, logic [PORCH_W-1:0] bp,
            logic [PORCH_W-1:0] fp, logic [CNT_W-1:0] act);
        case (ph)
            PH_SYNC: return CNT_W'(sw);
            PH_BACK: return CNT_W'(bp);
            PH_ACT:  return act;
            default: return CNT_W'(fp);
        endcase
    endfunction

    always_comb begin
        hlen      = seg_len(q.hph, hsw_m1, hbp_m1, hfp_m1, width_m1);
        vlen      = seg_len(q.vph, vsw_m1, vbp_m1, vfp_m1, height_m1);
        h_last    = (q.hcnt >= hlen);
        v_last    = (q.vcnt >= vlen);
        line_end  = h_last && (q.hph == PH_FRONT);
        frame_end = line_end && v_last && (q.vph == PH_FRONT);

        d = q;
        if (!run) begin
            d.hph  = PH_SYNC;
            d.hcnt = '0;
            d.vph  = PH_SYNC;
            d.vcnt = '0;
        end else if (tick) begin
            if (h_last) begin
                d.hcnt = '0;
                d.hph  = next_phase(q.hph);
                if (line_end) begin
                    if (v_last) begin
                        d.vcnt = '0;
                        d.vph  = next_phase(q.vph);
                    end else begin
                        d.vcnt = q.vcnt + 1'b1;
                    end
                end
            end else begin
                d.hcnt = q.hcnt + 1'b1;
            end
        end

        frame_wrap  = run && tick && frame_end;
        frame_start = run && tick && (q.hph == PH_SYNC) && (q.hcnt == '0) &&
                      (q.vph == PH_SYNC) && (q.vcnt == '0);

        hs_act = run && (q.hph == PH_SYNC);
        vs_act = run && (q.vph == PH_SYNC);
        de_act = run && (q.hph == PH_ACT) && (q.vph == PH_ACT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hph  <= PH_SYNC;
            q.hcnt <= '0;
            q.vph  <= PH_SYNC;
            q.vcnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign hsync_o = hs_act ^ pol[0];
    assign vsync_o = vs_act ^ pol[1];
    assign de_o    = de_act ^ pol[2];
    assign x_o     = de_act ? q.hcnt : '0;
    assign y_o     = de_act ? q.vcnt : '0;

    // R4: after a frame end the raster sits at its origin
    a_r4_origin_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (q.hph == PH_SYNC && q.hcnt == '0 &&
                        q.vph == PH_SYNC && q.vcnt == '0));

    // R5: visible coordinates stay inside the programmed size
    a_r5_de_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        de_act |-> (x_o <= width_m1 && y_o <= height_m1));

endmodule

// File: rtl/lcdt_irq.sv
module lcdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic irq_en,
    input  logic irq_clr,
    output logic irq_o
);
    logic pend_q, pend_d, set_ev;

    always_comb begin
        set_ev = frame_start && irq_en;
        pend_d = pend_q;
        if (set_ev)       pend_d = 1'b1;
        else if (irq_clr) pend_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign irq_o = pend_q & irq_en;

    // R10: a vsync start with the enable set leaves the flag pending
    a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && irq_en) |=> pend_q);

    // R10: a clear write without a coincident set drops the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(frame_start && irq_en)) |=> !pend_q);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3,
    parameter int CNT_W   = 11,
    parameter int PORCH_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [CNT_W-1:0]  x_o,
    output logic [CNT_W-1:0]  y_o,
    output logic              irq_o
);
    logic [PORCH_W-1:0] hsw_m1, hbp_m1, hfp_m1, vsw_m1, vbp_m1, vfp_m1;
    logic [CNT_W-1:0]   width_m1, height_m1;
    logic [2:0]         pol;
    logic               irq_en, irq_clr, run, div_sel, tick;
    logic [DIV_W-1:0]   div_m1;
    logic               frame_wrap, frame_start;

    lcdt_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .PORCH_W(PORCH_W), .DIV_W(DIV_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_wrap(frame_wrap),
        .hsw_m1(hsw_m1), .hbp_m1(hbp_m1), .hfp_m1(hfp_m1),
        .vsw_m1(vsw_m1), .vbp_m1(vbp_m1), .vfp_m1(vfp_m1),
        .width_m1(width_m1), .height_m1(height_m1), .pol(pol),
        .irq_en(irq_en), .irq_clr(irq_clr), .run(run),
        .div_sel(div_sel), .div_m1(div_m1)
    );

    lcdt_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel),
        .div_m1(div_m1), .tick(tick)
    );

    lcdt_scan #(.CNT_W(CNT_W), .PORCH_W(PORCH_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .hsw_m1(hsw_m1), .hbp_m1(hbp_m1), .hfp_m1(hfp_m1),
        .vsw_m1(vsw_m1), .vbp_m1(vbp_m1), .vfp_m1(vfp_m1),
        .width_m1(width_m1), .height_m1(height_m1), .pol(pol),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .x_o(x_o), .y_o(y_o),
        .frame_wrap(frame_wrap), .frame_start(frame_start)
    );

    lcdt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq_o(irq_o)
    );

endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o, vsync_o, de_o, irq_o;
    logic [10:0] x_o, y_o;

    always #10 clk = ~clk;

    lcd_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .x_o(x_o), .y_o(y_o), .irq_o(irq_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench copy of the programmed polarity and timing
    bit p_hs = 0, p_vs = 0, p_de = 0;
    int hsw, hbp, wid, hfp, vsw, vbp, hgt, vfp, dm1;
    bit dsel;

    int m_period, m_hs, m_vs, m_de, m_first, m_maxx, m_maxy;
    bit m_irq;

    function automatic int htot(); return hsw + hbp + wid + hfp; endfunction
    function automatic int vtot(); return vsw + vbp + hgt + vfp; endfunction
    function automatic int npix(); return dsel ? dm1 + 1 : 1; endfunction
    function automatic int period(); return npix() * htot() * vtot(); endfunction
    function automatic logic [31:0] ctrl_word(bit en);
        return {16'd0, 8'(dm1), 5'd0, dsel, en, en};
    endfunction

    function automatic bit hs_a(); return hsync_o ^ p_hs; endfunction
    function automatic bit vs_a(); return vsync_o ^ p_vs; endfunction
    function automatic bit de_a(); return de_o ^ p_de; endfunction

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_timing();
        wr(0, {8'd0, 8'(hfp-1), 8'(hbp-1), 8'(hsw-1)});
        wr(1, {8'd0, 8'(vfp-1), 8'(vbp-1), 8'(vsw-1)});
        wr(2, {5'd0, 11'(hgt-1), 5'd0, 11'(wid-1)});
    endtask

    // Measures from one vsync rise to the next (or to limit cycles)
    task automatic measure(input bit skip_wait, input int wr_at,
                           input logic [31:0] wr_val, input int limit);
        bit prev, cur;
        int cyc;
        if (!skip_wait) begin
            prev = vs_a();
            forever begin
                @(negedge clk);
                cur = vs_a();
                if (cur && !prev) break;
                prev = cur;
            end
        end
        m_hs = 0; m_vs = 0; m_de = 0; m_first = -1; m_maxx = 0; m_maxy = 0;
        m_irq = 0;
        cyc = 0;
        prev = 1'b1;
        forever begin
            if (hs_a()) m_hs++;
            if (vs_a()) m_vs++;
            if (de_a()) begin
                m_de++;
                if (m_first < 0) m_first = cyc;
                if (int'(x_o) > m_maxx) m_maxx = int'(x_o);
                if (int'(y_o) > m_maxy) m_maxy = int'(y_o);
            end
            if (cyc == npix() * htot() - 1) m_irq = irq_o;
            if (cyc == wr_at) begin
                wr_en = 1'b1; wr_addr = 3'd3; wr_data = wr_val;
            end
            @(negedge clk);
            if (wr_en) wr_en = 1'b0;
            cyc++;
            cur = vs_a();
            if ((cur && !prev) || cyc >= limit) break;
            prev = cur;
        end
        m_period = cyc;
    endtask

    task automatic check_frame(input string tag);
        int n;
        n = npix();
        chk("R6", {tag, " frame period"}, m_period, period());
        chk("R3", {tag, " hsync cycles"}, m_hs, n * hsw * vtot());
        chk("R4", {tag, " vsync cycles"}, m_vs, n * htot() * vsw);
        chk("R5", {tag, " de cycles"}, m_de, n * wid * hgt);
        chk("R3", {tag, " first de offset"}, m_first,
            n * (htot() * (vsw + vbp) + hsw + hbp));
        chk("R5", {tag, " max x"}, m_maxx, wid - 1);
        chk("R5", {tag, " max y"}, m_maxy, hgt - 1);
    endtask

    task automatic stop_and_idle(input string tag);
        wr(3, ctrl_word(0));
        repeat (period() + 10) @(negedge clk);
        chk("R11", {tag, " idle hsync"}, hsync_o, p_hs);
        chk("R11", {tag, " idle vsync"}, vsync_o, p_vs);
        chk("R11", {tag, " idle de"}, de_o, p_de);
    endtask

    task automatic count_activity(input int cycles, output int act);
        act = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (hs_a() || vs_a() || de_a()) act++;
        end
    endtask

    task automatic set_cfg(input int a, input int b, input int c, input int e,
                           input int f, input int g, input int h, input int i,
                           input bit s, input int dv);
        hsw = a; hbp = b; wid = c; hfp = e;
        vsw = f; vbp = g; hgt = h; vfp = i;
        dsel = s; dm1 = dv;
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 180000) begin
                fails++; checks++;
                $display("FAIL R3 watchdog actual=%0d expected=finish", cyc);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        int act;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "hsync after reset", hsync_o, 0);
        chk("R1", "vsync after reset", vsync_o, 0);
        chk("R1", "de after reset", de_o, 0);
        chk("R1", "x after reset", x_o, 0);
        chk("R1", "y after reset", y_o, 0);
        chk("R1", "irq after reset", irq_o, 0);

        // R7: one enable bit alone keeps the raster stopped
        wr(3, 32'h1);
        count_activity(80, act);
        chk("R7", "activity with only output enable", act, 0);
        wr(3, 32'h2);
        count_activity(80, act);
        chk("R7", "activity with only frame enable", act, 0);
        wr(3, 32'h0);
        repeat (4) @(negedge clk);

        // R2/R3/R4/R5/R6 directed and random geometries
        for (int c = 0; c < 7; c++) begin
            case (c)
                0: set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 1'b0, 0);
                1: set_cfg(2, 3, 5, 1, 2, 1, 3, 2, 1'b0, 5);    // R6 select off ignores field
                2: set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 1'b1, 255);  // R6 N=256
                default: set_cfg(1 + $urandom % 4, 1 + $urandom % 4,
                                 2 + $urandom % 7, 1 + $urandom % 4,
                                 1 + $urandom % 3, 1 + $urandom % 3,
                                 2 + $urandom % 4, 1 + $urandom % 3,
                                 1'b1, $urandom % 3);
            endcase
            program_timing();
            wr(3, ctrl_word(1));
            measure(0, -1, 0, 4 * period() + 100);
            check_frame($sformatf("R2 cfg%0d", c));
            stop_and_idle($sformatf("cfg%0d", c));
        end

        // R10 interrupt
        set_cfg(2, 1, 4, 1, 1, 1, 3, 1, 1'b1, 1);
        program_timing();
        wr(5, 32'h1);
        wr(3, ctrl_word(1));
        measure(0, -1, 0, 4 * period() + 100);
        chk("R10", "irq after vsync start", m_irq, 1);
        repeat (npix() * htot()) @(negedge clk);
        chk("R10", "irq still pending", irq_o, 1);
        wr(5, 32'h3);
        chk("R10", "irq after write-1 clear", irq_o, 0);
        wr(5, 32'h0);
        measure(0, -1, 0, 4 * period() + 100);
        chk("R10", "irq with enable clear", m_irq, 0);
        stop_and_idle("irq");

        // R9 polarity
        wr(4, 32'h7);
        p_hs = 1; p_vs = 1; p_de = 1;
        @(negedge clk);
        chk("R9", "idle hsync inverted", hsync_o, 1);
        chk("R9", "idle vsync inverted", vsync_o, 1);
        chk("R9", "idle de inverted", de_o, 1);
        set_cfg(3, 2, 6, 2, 2, 1, 4, 1, 1'b1, 0);
        program_timing();
        wr(3, ctrl_word(1));
        measure(0, -1, 0, 4 * period() + 100);
        check_frame("R9 inverted");
        stop_and_idle("pol");
        wr(4, 32'h0);
        p_hs = 0; p_vs = 0; p_de = 0;

        // R8 divider change deferred to the frame end
        set_cfg(2, 2, 5, 1, 1, 2, 3, 1, 1'b0, 0);
        program_timing();
        wr(3, ctrl_word(1));
        measure(0, -1, 0, 4 * period() + 100);
        dsel = 1; dm1 = 2;
        begin
            logic [31:0] nw;
            nw = ctrl_word(1);
            dsel = 0; dm1 = 0;
            measure(1, 5, nw, 4 * period() + 100);
        end
        chk("R8", "period of frame with pending divider", m_period, period());
        dsel = 1; dm1 = 2;
        measure(1, -1, 0, 4 * period() + 100);
        check_frame("R8 new divider");

        // R11 stop request lets the frame finish, then silence
        measure(1, 5, ctrl_word(0), 3 * period());
        chk("R11", "window without further vsync", m_period, 3 * period());
        chk("R11", "hsync cycles of finishing frame", m_hs, npix() * hsw * vtot());
        chk("R11", "de cycles of finishing frame", m_de, npix() * wid * hgt);
        chk("R11", "vsync cycles of finishing frame", m_vs, npix() * htot() * vsw);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule